// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block lines up a fixed number of participants at a synchronisation point and lets them all go at once. Before each barrier episode a participant flips its own sense bit, then pulses its arrive input with that new sense. The block keeps a shared arrival count. Several arrivals in the same cycle are all counted. When the arrival that completes the group lands, the count returns to zero and a shared flag takes the sense carried by that arrival.

Each participant has a go output. It is high while the shared flag equals the sense that participant last arrived with. A participant therefore waits with go low from its arrival until the group completes. Because the sense alternates from one episode to the next, the same counter and flag serve back-to-back episodes. A participant that enters the next episode early only changes its own stored sense, so it cannot hold back anyone who is still leaving the current one.

A second arrival from a participant that is already counted in the open episode is reported on an error output and is not counted.

Top module: `sr_barrier`

## Requirements
- R1: An accepted arrival on port i stores the `arr_sense[i]` value given with it as that port's local sense, visible from the next cycle.
- R2: All accepted arrivals in one cycle are counted together. The counter advances by the number of set bits among the accepted arrive inputs.
- R3: When the count plus this cycle's accepted arrivals equals PARTIES, the count returns to zero. On the next cycle `gflag` equals the `arr_sense` of the lowest-numbered port accepted in that cycle.
- R4: `go[i]` is 1 exactly when `gflag` equals port i's stored local sense. It therefore drops to 0 after an arrival and returns to 1 when the episode completes.
- R5: An accepted arrival that opens the next episode changes only that port's `go` bit. The `go` bits of all other ports and `gflag` keep their values.
- R6: An arrive pulse on a port already counted in the open episode is not counted. In the next cycle `dup_err` has that port's bit set; otherwise `dup_err` is 0.
- R7: After reset the count, `gflag`, every stored local sense and `dup_err` are 0, so `go` is all ones.
- R8: Successive completed episodes drive `gflag` alternately to 1 and 0 when participants flip their sense each episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive | input | PARTIES | One-cycle arrival pulse per participant |
| arr_sense | input | PARTIES | Local sense carried with each arrival |
| go | output | PARTIES | Per-participant release, high while the shared flag matches the local sense |
| gflag | output | 1 | Shared flag published at episode completion |
| dup_err | output | PARTIES | Per-port pulse for a repeated arrival within one episode |

## Verification
The checker assumes that every accepted arrival carries a sense opposite to the current shared flag. In other words, each participant flips its sense exactly once per episode before it arrives. The stimulus keeps a per-port model of the sense and flips it before every new arrival. A repeated arrival is sent only while the port is still counted in the open episode, and it carries the same sense, so the assumption still holds.

// File: rtl/sr_barrier.sv
module sr_barrier #(
  parameter int PARTIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PARTIES-1:0] arrive,
  input  logic [PARTIES-1:0] arr_sense,
  output logic [PARTIES-1:0] go,
  output logic               gflag,
  output logic [PARTIES-1:0] dup_err
);
  localparam int CW = $clog2(PARTIES + 1);
  localparam logic [CW:0] FULL = (CW+1)'(PARTIES);

  logic [CW-1:0]      cnt;
  logic [PARTIES-1:0] seen;
  logic [PARTIES-1:0] lsense;
  logic [CW-1:0]      add;
  logic               pick;
  logic               found;
  logic [CW:0]        total;
  logic               done;

  wire [PARTIES-1:0] fresh = arrive & ~seen;

  always_comb begin
    add   = '0;
    pick  = 1'b0;
    found = 1'b0;
    for (int i = 0; i < PARTIES; i++) begin
      if (fresh[i]) begin
        add = add + CW'(1);
        if (!found) begin
          pick  = arr_sense[i];
          found = 1'b1;
        end
      end
    end
  end

  assign total = {1'b0, cnt} + {1'b0, add};
  assign done  = (total == FULL);
  assign go    = ~({PARTIES{gflag}} ^ lsense);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      seen    <= '0;
      lsense  <= '0;
      gflag   <= 1'b0;
      dup_err <= '0;
    end else begin
      dup_err <= arrive & seen;
      lsense  <= (lsense & ~fresh) | (arr_sense & fresh);
      if (done) begin
        cnt   <= '0;
        seen  <= '0;
        gflag <= pick;
      end else begin
        cnt  <= total[CW-1:0];
        seen <= seen | fresh;
      end
    end
  end
endmodule

// File: rtl/sr_barrier_chk.sv
module sr_barrier_chk #(
  parameter int PARTIES = 4,
  parameter int CW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PARTIES-1:0] arrive,
  input logic [PARTIES-1:0] arr_sense,
  input logic [PARTIES-1:0] go,
  input logic               gflag,
  input logic [PARTIES-1:0] dup_err,
  input logic [CW-1:0]      cnt,
  input logic [PARTIES-1:0] seen
);
  wire [PARTIES-1:0] acc = arrive & ~seen;

  // R1: input assumption, accepted arrivals carry the opposite of gflag
  p_sense_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc & ~({PARTIES{gflag}} ^ arr_sense)) == '0);

  // R2: the count never reaches the group size
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PARTIES));

  // R3: the flag moves only in a cycle after an accepted arrival
  p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gflag) |-> $past(|acc));

  // R4: at completion every port is released
  p_all_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gflag) |-> (&go));

  // R6: a repeated arrival is reported and leaves the count unchanged
  p_dup_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(arrive & seen)) |=> (dup_err == $past(arrive & seen)));
  p_dup_nocount_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(arrive & seen)) && !(|acc)) |=> $stable(cnt));

  // R7: reset state
  p_reset_r7: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && !gflag && (&go) && dup_err == '0));
endmodule

bind sr_barrier sr_barrier_chk #(.PARTIES(PARTIES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arrive(arrive), .arr_sense(arr_sense),
  .go(go), .gflag(gflag), .dup_err(dup_err), .cnt(cnt), .seen(seen)
);

// File: tb/sim_sr_barrier.sv
module sim_sr_barrier;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] arr_sense = '0;
  logic [N-1:0] go;
  logic         gflag;
  logic [N-1:0] dup_err;

  int runs = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  sr_barrier #(.PARTIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .arr_sense(arr_sense),
    .go(go), .gflag(gflag), .dup_err(dup_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] a, logic [N-1:0] s);
    arrive = a;
    arr_sense = s;
    @(negedge clk);
    arrive = '0;
  endtask

  task automatic t_reset;
    chk("R7 go", 32'(go), 32'hF);
    chk("R7 gflag", 32'(gflag), 0);
    chk("R7 dup_err", 32'(dup_err), 0);
  endtask

  task automatic t_basic;
    step(4'b0001, 4'b1111);
    chk("R1 go after first arrival", 32'(go), 32'hE);
    step(4'b0010, 4'b1111);
    chk("R4 go after two", 32'(go), 32'hC);
    step(4'b0100, 4'b1111);
    chk("R4 go after three", 32'(go), 32'h8);
    chk("R3 flag held", 32'(gflag), 0);
    step(4'b1000, 4'b1111);
    chk("R3 go at completion", 32'(go), 32'hF);
    chk("R3 flag set", 32'(gflag), 1);
  endtask

  task automatic t_simul;
    step(4'b0011, 4'b0000);
    chk("R2 pair counted", 32'(go), 32'hC);
    step(4'b1100, 4'b0000);
    chk("R2 completion", 32'(go), 32'hF);
    chk("R8 flag back to 0", 32'(gflag), 0);
  endtask

  task automatic t_dup;
    step(4'b0001, 4'b1111);
    chk("R6 no err first", 32'(dup_err), 0);
    step(4'b0001, 4'b1111);
    chk("R6 err bit", 32'(dup_err), 32'h1);
    chk("R6 go unchanged", 32'(go), 32'hE);
    step(4'b0110, 4'b1111);
    chk("R6 not counted", 32'(go), 32'h8);
    chk("R6 flag held", 32'(gflag), 0);
    chk("R6 err clears", 32'(dup_err), 0);
    step(4'b1000, 4'b1111);
    chk("R8 flag to 1", 32'(gflag), 1);
    chk("R4 all go", 32'(go), 32'hF);
  endtask

  task automatic t_early;
    step(4'b0111, 4'b0000);
    chk("R2 three at once", 32'(go), 32'h8);
    step(4'b1000, 4'b0000);
    chk("R8 flag to 0", 32'(gflag), 0);
    step(4'b0001, 4'b1111);
    chk("R5 others stay released", 32'(go), 32'hE);
    chk("R5 flag held", 32'(gflag), 0);
    step(4'b1110, 4'b1111);
    chk("R3 next episode", 32'(gflag), 1);
    chk("R4 all go again", 32'(go), 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_simul();
    t_dup();
    t_early();
    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!ended) begin
      runs++;
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule